// File: doc/BRIEF.md
# Serial Flash Command Frame Sequencer

This block runs one serial-flash command frame. It drives the chip select, the serial clock and four IO lanes, each lane with its own output enable. A 32-bit command word sets the shape of the frame. The frame can carry an opcode byte and up to four address bytes taken from a 32-bit address word. It can then carry up to seven intermediate bytes taken from a 32-bit intermediate word, followed by a data phase of up to 16383 bytes in either direction. Each field goes out on one lane or on several lanes, as the command word selects.

A frame starts on a one-cycle `start` pulse while the block is idle. The block copies the three configuration words into registers at that point. The serial clock advances only on cycles where `tick` is high, and each SCK period takes two ticks. Outgoing data bytes are taken through a valid/ready pair. Incoming data bytes are returned as one-cycle valid pulses. A `done` pulse marks the cycle in which chip select rises again.

Command word layout (bit ranges inclusive):
- opcode [31:24]
- frame code [23:21]
- field code [20:19]
- intermediate count [18:16]
- direction [15]
- lane-set select [14]
- data length [13:0]

Top module: `flash_frame_seq`

## Requirements
- R1: Frame code 1 sends only the opcode (command word bits [31:24]). Frame codes 2, 3, 4 and 5 send the opcode, then 1, 2, 3 and 4 address bytes respectively.
- R2: Frame codes 6 and 7 send no opcode, then 3 and 4 address bytes respectively. Frame code 0 sends neither an opcode nor an address.
- R3: When N address bytes are sent, they are the N low bytes of the address word, and the most significant of them goes first. Every byte is shifted out most significant bit first.
- R4: Field code 0 puts every field on one lane. Field code 1 widens only the data field. Field code 2 widens every field except the opcode. Field code 3 widens every field.
- R5: Lane-set select 1 makes widened fields use IO1:0, 2 bits per SCK with the higher bit on IO1. Lane-set select 0 makes them use IO3:0, 4 bits per SCK with the highest bit on IO3. A single-lane field drives IO0 and reads IO1. The output enables are exactly the lanes in use (0001, 0011 or 1111).
- R6: The intermediate count gives the number of bytes (0 to 7) sent between the address and data phases. Intermediate byte k comes from byte (k mod 4) of the intermediate word, where byte 0 is the least significant.
- R7: The data length gives the number of data bytes, and a length of 0 means the frame has no data phase. With direction 1, each data byte is taken on a cycle with `tx_valid` and `tx_ready` both high. The clock holds while no byte is offered.
- R8: With direction 0, all output enables are low for the whole data phase. The lanes are sampled on SCK rising edges, and each completed byte is presented on `rx_byte` with a one-cycle `rx_valid`.
- R9: While chip select is high, SCK rests at the level of `sck_idle_high`. SCK makes no rising edge between the last sampled bit and the rise of chip select. `done` pulses when chip select rises, and `busy` is low exactly when the block is idle.
- R10: While chip select is high, all output enables are low.
- R11: A `start` pulse while a frame is running is ignored. The running frame and its configuration are unchanged, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a frame when idle |
| cmd_word | input | 32 | Command word (layout above) |
| addr_word | input | 32 | Address word |
| imm_word | input | 32 | Intermediate-byte word |
| sck_idle_high | input | 1 | 1: SCK rests high while deselected |
| tick | input | 1 | SCK half-period enable |
| tx_byte | input | 8 | Outgoing data byte |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | Outgoing byte taken this cycle when valid |
| rx_byte | output | 8 | Received data byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| io_in | input | 4 | Lane input values |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse as chip select rises |

## Verification
If the phase or byte-count state goes wrong, the number of SCK rising edges changes. The lanes also carry the wrong byte at the very next rising edge, and that edge is flagged against the requirement for that field. If the lane width is wrong, the output enables and the edge count for the whole field are off. A bit-counter slip shifts every later edge in the frame. A direction error shows as driven enables, or as a missing or wrong `rx_byte`, within the first data byte. A fault in the frame end shows within one tick of the last edge: a stray SCK edge, chip select stuck low, or a missing `done`.

// File: rtl/fseq_pkg.sv
// Shared types for the serial flash frame sequencer.
// Assumes a 32-bit command word whose fields are laid out as in cmd_t.
package fseq_pkg;
    localparam int DLEN_W = 14;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] opc;
        logic [2:0]        frm;
        logic [1:0]        fld;
        logic [2:0]        nimm;
        logic              dir_out;
        logic              dual;
        logic [DLEN_W-1:0] dlen;
    } cmd_t;

    typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_IMM, PH_DAT, PH_NONE} phase_e;
    typedef enum logic [1:0] {LN_ONE, LN_TWO, LN_FOUR} lane_e;
    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_FIN} state_e;
endpackage

// File: rtl/fseq_plan.sv
// Frame planner: turns command fields into per-phase byte counts.
// Finds the first non-empty phase and the next one after the current phase,
// and selects the lane width of the current phase.
// Assumes phases always run in the order opcode, address, intermediate, data.
module fseq_plan
    import fseq_pkg::*;
(
    input  logic [2:0]        frm,
    input  logic [1:0]        fld,
    input  logic [2:0]        nimm,
    input  logic [DLEN_W-1:0] dlen,
    input  logic              dual,
    input  phase_e            cur,
    output phase_e            first_ph,
    output logic [DLEN_W-1:0] first_cnt,
    output phase_e            next_ph,
    output logic [DLEN_W-1:0] next_cnt,
    output lane_e             cur_lane
);
    logic [DLEN_W-1:0] cnt [4];
    logic              multi;

    // Byte count of each phase from the frame code.
    always_comb begin
        cnt[0] = (frm >= 3'd1 && frm <= 3'd5) ? DLEN_W'(1) : '0;
        case (frm)
            3'd2:    cnt[1] = DLEN_W'(1);
            3'd3:    cnt[1] = DLEN_W'(2);
            3'd4:    cnt[1] = DLEN_W'(3);
            3'd5:    cnt[1] = DLEN_W'(4);
            3'd6:    cnt[1] = DLEN_W'(3);
            3'd7:    cnt[1] = DLEN_W'(4);
            default: cnt[1] = '0;
        endcase
        cnt[2] = DLEN_W'(nimm);
        cnt[3] = dlen;
    end

    // Lowest non-empty phase overall, and lowest non-empty phase after cur.
    always_comb begin
        first_ph  = PH_NONE;
        first_cnt = '0;
        next_ph   = PH_NONE;
        next_cnt  = '0;
        for (int i = 3; i >= 0; i--) begin
            if (cnt[i] != '0) begin
                first_ph  = phase_e'(i);
                first_cnt = cnt[i];
                if (i > int'(cur)) begin
                    next_ph  = phase_e'(i);
                    next_cnt = cnt[i];
                end
            end
        end
    end

    // Lane width of the current phase from the field code.
    always_comb begin
        case (cur)
            PH_OPC:         multi = (fld == 2'd3);
            PH_ADR, PH_IMM: multi = fld[1];
            PH_DAT:         multi = (fld != 2'd0);
            default:        multi = 1'b0;
        endcase
        cur_lane = multi ? (dual ? LN_TWO : LN_FOUR) : LN_ONE;
    end
endmodule

// File: rtl/fseq_lanes.sv
// Lane mapper: places the top bits of the shift register on the IO lanes,
// and builds the next shift value for either transmit or receive.
// Assumes MSB-first order, with the higher bit on the higher lane.
module fseq_lanes
    import fseq_pkg::*;
(
    input  logic [BYTE_W-1:0] sh,
    input  lane_e             lane,
    input  logic              drive,
    input  logic [LANES-1:0]  io_in,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    output logic [BYTE_W-1:0] sh_out,
    output logic [BYTE_W-1:0] sh_in,
    output logic [2:0]        grp_init
);
    // Per-width lane placement and shift step.
    always_comb begin
        case (lane)
            LN_TWO: begin
                io_out   = {2'b00, sh[7:6]};
                io_oe    = 4'b0011;
                sh_out   = {sh[5:0], 2'b00};
                sh_in    = {sh[5:0], io_in[1:0]};
                grp_init = 3'd3;
            end
            LN_FOUR: begin
                io_out   = sh[7:4];
                io_oe    = 4'b1111;
                sh_out   = {sh[3:0], 4'b0000};
                sh_in    = {sh[3:0], io_in};
                grp_init = 3'd1;
            end
            default: begin
                io_out   = {3'b000, sh[7]};
                io_oe    = 4'b0001;
                sh_out   = {sh[6:0], 1'b0};
                sh_in    = {sh[6:0], io_in[1]};
                grp_init = 3'd7;
            end
        endcase
        if (!drive) begin
            io_out = '0;
            io_oe  = '0;
        end
    end
endmodule

// File: rtl/flash_frame_seq.sv
// Serial flash command frame sequencer (top).
// Runs one frame per start pulse: optional opcode, address bytes,
// intermediate bytes and a data phase, each at its own lane width.
// Assumes tick pulses no faster than the clock; each SCK period takes two ticks.
module flash_frame_seq
    import fseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] cmd_word,
    input  logic [31:0] addr_word,
    input  logic [31:0] imm_word,
    input  logic        sck_idle_high,
    input  logic        tick,
    input  logic [7:0]  tx_byte,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic [7:0]  rx_byte,
    output logic        rx_valid,
    input  logic [3:0]  io_in,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    output logic        sck,
    output logic        cs_n,
    output logic        busy,
    output logic        done
);
    state_e            st;
    phase_e            ph;
    cmd_t              cmd_q;
    cmd_t              plan_cmd;
    logic [31:0]       addr_q, imm_q;
    logic [DLEN_W-1:0] rem;
    logic [2:0]        grp;
    logic [7:0]        sh, ld, rx_q;
    logic              sck_r, cs_r, rx_v_q, done_q;
    phase_e            first_ph, next_ph;
    logic [DLEN_W-1:0] first_cnt, next_cnt;
    lane_e             lane;
    logic [7:0]        sh_out, sh_in;
    logic [2:0]        grp_init;
    logic              dat_in, drive, can_load;
    logic [1:0]        aidx, iidx;

    // Plan from the live command word while idle, from the copy during a frame.
    assign plan_cmd = (st == ST_IDLE) ? cmd_t'(cmd_word) : cmd_q;

    fseq_plan u_plan (
        .frm(plan_cmd.frm), .fld(plan_cmd.fld), .nimm(plan_cmd.nimm),
        .dlen(plan_cmd.dlen), .dual(plan_cmd.dual), .cur(ph),
        .first_ph(first_ph), .first_cnt(first_cnt),
        .next_ph(next_ph), .next_cnt(next_cnt), .cur_lane(lane)
    );

    assign dat_in = (ph == PH_DAT) && !cmd_q.dir_out;
    assign drive  = (st != ST_IDLE) && (ph != PH_NONE) && !dat_in;

    fseq_lanes u_lanes (
        .sh(sh), .lane(lane), .drive(drive), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .sh_out(sh_out), .sh_in(sh_in),
        .grp_init(grp_init)
    );

    // Byte to load for the current phase; remaining count selects the byte.
    always_comb begin
        aidx = rem[1:0] - 2'd1;
        iidx = cmd_q.nimm[1:0] - rem[1:0];
        case (ph)
            PH_OPC:  ld = cmd_q.opc;
            PH_ADR:  ld = addr_q[{aidx, 3'b000} +: 8];
            PH_IMM:  ld = imm_q[{iidx, 3'b000} +: 8];
            PH_DAT:  ld = cmd_q.dir_out ? tx_byte : 8'h00;
            default: ld = 8'h00;
        endcase
    end

    assign tx_ready = (st == ST_LOAD) && (ph == PH_DAT) && cmd_q.dir_out;
    assign can_load = !(tx_ready && !tx_valid);

    // Frame sequencing: load a byte, run its SCK groups, then step phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  ph <= PH_NONE;  cmd_q <= '0;
            addr_q <= '0;   imm_q <= '0;    rem <= '0;
            grp <= '0;      sh <= '0;       sck_r <= 1'b0;
            cs_r <= 1'b1;   rx_q <= '0;     rx_v_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            rx_v_q <= 1'b0;
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    cmd_q  <= cmd_t'(cmd_word);
                    addr_q <= addr_word;
                    imm_q  <= imm_word;
                    cs_r   <= 1'b0;
                    sck_r  <= 1'b0;
                    ph     <= first_ph;
                    rem    <= first_cnt;
                    st     <= (first_ph == PH_NONE) ? ST_FIN : ST_LOAD;
                end
                ST_LOAD: if (can_load) begin
                    sh  <= ld;
                    grp <= grp_init;
                    st  <= ST_SHIFT;
                end
                ST_SHIFT: if (tick) begin
                    if (!sck_r) begin
                        sck_r <= 1'b1;
                        if (dat_in) begin
                            sh <= sh_in;
                            if (grp == 3'd0) begin
                                rx_q   <= sh_in;
                                rx_v_q <= 1'b1;
                            end
                        end
                        if (grp == 3'd0 && rem == DLEN_W'(1) && next_ph == PH_NONE)
                            st <= ST_FIN;
                    end else begin
                        sck_r <= 1'b0;
                        if (grp != 3'd0) begin
                            grp <= grp - 3'd1;
                            if (!dat_in) sh <= sh_out;
                        end else if (rem != DLEN_W'(1)) begin
                            rem <= rem - DLEN_W'(1);
                            st  <= ST_LOAD;
                        end else begin
                            ph  <= next_ph;
                            rem <= next_cnt;
                            st  <= ST_LOAD;
                        end
                    end
                end
                ST_FIN: if (tick) begin
                    cs_r   <= 1'b1;
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sck      = (st == ST_IDLE) ? sck_idle_high : sck_r;
    assign cs_n     = cs_r;
    assign busy     = (st != ST_IDLE);
    assign done     = done_q;
    assign rx_byte  = rx_q;
    assign rx_valid = rx_v_q;
endmodule

// File: rtl/fseq_checker.sv
// Protocol checker for the frame sequencer, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module fseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       sck_idle_high,
    input logic [3:0] io_oe,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       busy,
    input logic       done
);
    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> io_oe == 4'h0); // R10
    AST_OE_LANE_SET: assert property (@(posedge clk) disable iff (!rst_n) (io_oe == 4'h0) || (io_oe == 4'h1) || (io_oe == 4'h3) || (io_oe == 4'hF)); // R5
    AST_RX_LANES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> io_oe == 4'h0); // R8
    AST_TX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> !cs_n); // R7
    AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n && !busy); // R9
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R9
    AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cs_n && $past(cs_n) && $stable(sck_idle_high) |-> $stable(sck)); // R9
endmodule

bind flash_frame_seq fseq_checker u_fseq_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .sck_idle_high(sck_idle_high), .io_oe(io_oe), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .busy(busy), .done(done)
);

// File: tb/flash_frame_seq_bench.sv
module flash_frame_seq_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0, start = 1'b0, sck_idle_high = 1'b0, tick = 1'b1;
    logic [31:0] cmd_word = '0, addr_word = '0, imm_word = '0;
    logic [7:0]  tx_byte = '0;
    logic        tx_valid = 1'b0;
    logic [3:0]  io_in = '0;
    logic        tx_ready, rx_valid, sck, cs_n, busy, done;
    logic [7:0]  rx_byte;
    logic [3:0]  io_out, io_oe;

    flash_frame_seq u_flash_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .addr_word(addr_word), .imm_word(imm_word), .sck_idle_high(sck_idle_high),
        .tick(tick), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .io_in(io_in), .io_out(io_out),
        .io_oe(io_oe), .sck(sck), .cs_n(cs_n), .busy(busy), .done(done)
    );

    int checks = 0, errors = 0;
    logic [3:0] e_out [0:511];
    logic [3:0] e_oe  [0:511];
    logic [3:0] e_in  [0:511];
    string      e_tag [0:511];
    int         n_edges;
    logic [7:0] txq [0:31];
    logic [7:0] rxq [0:31];
    logic [7:0] rx_got [0:31];
    int  edge_i = 0, bad_n = 0, rx_n = 0, tx_n = 0;
    string bad_tag;
    logic [7:0] bad_act, bad_exp;
    logic hs = 1'b0, cur_dual = 1'b0, rand_tick = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected edges for one byte at the given width and direction.
    task automatic push_byte(input logic [7:0] b, input bit multi, input bit is_out, input string tag);
        int w;
        w = multi ? (cur_dual ? 2 : 4) : 1;
        for (int g = 0; g < 8 / w; g++) begin
            logic [3:0] v;
            v = '0;
            for (int k = 0; k < w; k++) v[w-1-k] = b[7-g*w-k];
            if (is_out) begin
                e_oe[n_edges]  = (w == 1) ? 4'h1 : (w == 2) ? 4'h3 : 4'hF;
                e_out[n_edges] = v;
                e_in[n_edges]  = '0;
            end else begin
                e_oe[n_edges]  = '0;
                e_out[n_edges] = '0;
                e_in[n_edges]  = (w == 1) ? {2'b00, v[0], 1'b0} : v;
            end
            e_tag[n_edges] = multi ? (cur_dual ? "R5" : "R4") : tag;
            n_edges++;
        end
    endtask

    // Expected frame from the requirements.
    task automatic build(input logic [31:0] c, input logic [31:0] a, input logic [31:0] im);
        int nadr;
        logic [2:0] frm;
        logic [1:0] fld;
        frm = c[23:21];
        fld = c[20:19];
        cur_dual = c[14];
        n_edges = 0;
        if (frm >= 3'd1 && frm <= 3'd5) push_byte(c[31:24], fld == 2'd3, 1'b1, "R1");
        case (frm)
            3'd2: nadr = 1;  3'd3: nadr = 2;  3'd4: nadr = 3;
            3'd5: nadr = 4;  3'd6: nadr = 3;  3'd7: nadr = 4;
            default: nadr = 0;
        endcase
        for (int i = nadr - 1; i >= 0; i--) push_byte(a[8*i +: 8], fld[1], 1'b1, "R3");
        for (int i = 0; i < int'(c[18:16]); i++) push_byte(im[8*(i%4) +: 8], fld[1], 1'b1, "R6");
        for (int d = 0; d < int'(c[13:0]); d++)
            if (c[15]) push_byte(txq[d], fld != 2'd0, 1'b1, "R7");
            else       push_byte(rxq[d], fld != 2'd0, 1'b0, "R8");
    endtask

    // Flash-side monitor: compare lanes at each rising SCK while selected.
    always @(posedge sck) if (!cs_n) begin
        #1;
        if (edge_i >= n_edges) begin
            if (bad_n == 0) begin bad_tag = "R9"; bad_act = 8'hEE; bad_exp = 8'h00; end
            bad_n++;
        end else if (io_oe != e_oe[edge_i] || (io_out & io_oe) != e_out[edge_i]) begin
            if (bad_n == 0) begin
                bad_tag = e_tag[edge_i];
                bad_act = {io_oe, io_out & io_oe};
                bad_exp = {e_oe[edge_i], e_out[edge_i]};
            end
            bad_n++;
        end
        edge_i++;
    end

    // Flash-side responder: present the next input group after each fall.
    always @(negedge sck) if (!cs_n) begin #1; io_in = e_in[edge_i]; end
    always @(negedge cs_n) begin #1; io_in = e_in[0]; end

    always @(posedge clk) hs <= tx_valid && tx_ready;

    // Data source, receive collector and tick generator.
    always @(negedge clk) begin
        if (rx_valid) begin rx_got[rx_n] = rx_byte; rx_n++; end
        if (hs) begin
            tx_n++;
            tx_byte  = txq[tx_n];
            tx_valid = ($urandom % 4) != 0;
        end else if (!tx_valid) tx_valid = ($urandom % 2) != 0;
        tick = rand_tick ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic run_frame(input logic [31:0] c, input logic [31:0] a, input logic [31:0] im,
                             input bit m3, input bit glitch);
        int t;
        bit seen;
        string ftag;
        for (int i = 0; i < 32; i++) begin txq[i] = 8'($urandom); rxq[i] = 8'($urandom); end
        build(c, a, im);
        ftag = (c[23:21] == 3'd0 || c[23:21] >= 3'd6) ? "R2" : "R1";
        edge_i = 0; bad_n = 0; rx_n = 0; tx_n = 0;
        @(negedge clk);
        tx_byte = txq[0]; tx_valid = 1'b1;
        cmd_word = c; addr_word = a; imm_word = im; sck_idle_high = m3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            repeat (5) @(negedge clk);
            cmd_word = ~c; addr_word = ~a; imm_word = ~im; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0; seen = done;
        while (!seen && t < 20000) begin @(negedge clk); seen = done; t++; end
        chk(seen, "R9", "done pulse seen", seen, 1);
        chk(edge_i == n_edges, ftag, "rising SCK count", edge_i, n_edges);
        chk(bad_n == 0, bad_tag, "lane value at first bad edge", bad_act, bad_exp);
        if (c[13:0] != 0 && !c[15]) begin
            bit ok;
            ok = (rx_n == int'(c[13:0]));
            for (int i = 0; i < rx_n && i < 32; i++) if (rx_got[i] != rxq[i]) ok = 0;
            chk(ok, "R8", "received bytes", rx_n, c[13:0]);
        end
        if (c[15]) chk(tx_n == int'(c[13:0]), "R7", "bytes taken", tx_n, c[13:0]);
        @(negedge clk);
        chk(cs_n && sck == m3 && io_oe == 4'h0, "R10", "idle pins {cs,sck,oe}",
            {cs_n, sck, io_oe}, {1'b1, m3, 4'h0});
        if (glitch) begin
            bit quiet;
            quiet = 1;
            repeat (20) begin @(negedge clk); if (!cs_n || busy) quiet = 0; end
            chk(quiet, "R11", "no frame after ignored start", quiet, 1);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] opc, input int frm, input int fld,
                                       input int nimm, input bit dout, input bit dual, input int dlen);
        return {opc, 3'(frm), 2'(fld), 3'(nimm), dout, dual, 14'(dlen)};
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: run still active, actual %0d cycles expected fewer", 1000000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        chk(cs_n && !busy && io_oe == 4'h0 && sck == 1'b0 && !done, "R10",
            "reset pins {cs,busy,oe}", {cs_n, busy, io_oe}, {2'b10, 4'h0});
        rst_n = 1'b1;
        run_frame(mk(8'h9F, 1, 0, 0, 0, 0, 0), 32'h0, 32'h0, 1'b0, 1'b0);             // R1 opcode only
        run_frame(mk(8'hEB, 5, 3, 2, 0, 0, 4), 32'hA1B2C3D4, 32'h11223344, 1'b1, 1'b0); // R4 quad all
        run_frame(mk(8'h00, 6, 2, 1, 0, 1, 3), 32'h00ABCDEF, 32'h000000F0, 1'b0, 1'b0); // R2 R5 dual
        run_frame(mk(8'h00, 7, 1, 0, 1, 1, 5), 32'h12345678, 32'h0, 1'b1, 1'b0);       // R2 R7 out
        run_frame(mk(8'h55, 0, 0, 0, 0, 0, 0), 32'h0, 32'h0, 1'b0, 1'b0);             // R2 empty frame
        run_frame(mk(8'h3B, 2, 0, 7, 0, 0, 2), 32'h000000C7, 32'h8899AABB, 1'b1, 1'b0); // R6 wrap
        run_frame(mk(8'h02, 4, 0, 0, 1, 0, 6), 32'h00654321, 32'h0, 1'b0, 1'b1);       // R11 + R3
        rand_tick = 1'b1;
        for (int n = 0; n < 40; n++)
            run_frame(mk(8'($urandom), $urandom % 8, $urandom % 4, $urandom % 8,
                         1'($urandom), 1'($urandom), $urandom % 9),
                      $urandom, $urandom, 1'($urandom), 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule